// File: doc/BRIEF.md
# Lane-Split Dual-Width Byte FIFO

This block buffers data between a host register port and a serial shifter. Storage is four independent byte lanes, each a 16-entry FIFO. A 32-bit word access from the host writes or reads all four lanes in the same cycle, so the buffer holds up to 64 bytes when used word-wise. A byte access touches lane 0 alone, so it holds 16 bytes when used byte-wise.

On the shifter side the block moves one byte per accepted strobe. In word mode a rotating lane index walks lanes 0, 1, 2, 3 and then wraps, so the bytes of a word are consumed or produced least significant byte first. In byte mode the shifter side stays on lane 0. The same block serves a transmit path (host writes, shifter pops) and a receive path (shifter pushes, host reads). Registered status flags let software poll before each access: full, half-full, empty, word-available and byte-available. A synchronous clear input empties every lane.

Top module: `lane_split_fifo`

## Requirements
- R1: After reset, or in the cycle after `clr` is high, every lane is empty and both shifter lane indices are back at lane 0: `empty`=1 and `full`, `half_full`, `word_avail`, `byte_avail` are 0. `clr` overrides every strobe in its cycle.
- R2: A word write stores `host_wdata[8k+7:8k]` into lane k for k=0..3. It is accepted only when no lane is full. A word read pops one byte from every lane and returns them in the same layout on `host_rdata` in the next cycle. It is accepted only when every lane holds an entry.
- R3: A byte write stores `host_wdata[7:0]` into lane 0 only. A byte read pops lane 0 and returns it on `host_rdata[7:0]` with bits 31:8 zero in the next cycle.
- R4: With `word_mode`=1, accepted shifter pops take lanes 0,1,2,3 in turn and then wrap. Each popped byte appears on `shf_rdata` in the next cycle.
- R5: With `word_mode`=1, accepted shifter pushes fill lanes 0,1,2,3 in turn and then wrap. The lane index advances only on an accepted push.
- R6: With `word_mode`=0, shifter pushes and pops use lane 0 only, and the lane indices do not move.
- R7: `full` is 1 when any lane holds 16 entries. A write to a full lane is ignored, and a word write is ignored as a whole if any lane is full.
- R8: `empty` is 1 when every lane is empty. A pop of an empty lane is ignored, and the matching data output holds its value.
- R9: `half_full` is 1 when lane 0 holds 8 or more entries.
- R10: `word_avail` is 1 when every lane holds at least one entry. `byte_avail` is 1 when lane 0 holds at least one entry.
- R11: A push and a pop accepted on the same lane in the same cycle leave that lane's occupancy unchanged and keep FIFO order.
- R12: A word strobe takes precedence over the byte strobe of the same kind. A shifter push is ignored in any cycle with a host write strobe. A shifter pop is ignored in any cycle with a host read strobe.
- R13: All flags and data outputs are registered. They reflect an access in the cycle after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| clr | input | 1 | Synchronous clear of all lanes |
| word_mode | input | 1 | 1: shifter rotates over all lanes; 0: shifter uses lane 0 |
| host_wr_word | input | 1 | Host word write strobe |
| host_wr_byte | input | 1 | Host byte write strobe |
| host_wdata | input | 32 | Host write data |
| host_rd_word | input | 1 | Host word read strobe |
| host_rd_byte | input | 1 | Host byte read strobe |
| host_rdata | output | 32 | Host read data, registered |
| shf_push | input | 1 | Shifter byte push strobe |
| shf_wdata | input | 8 | Shifter push data |
| shf_pop | input | 1 | Shifter byte pop strobe |
| shf_rdata | output | 8 | Shifter pop data, registered |
| full | output | 1 | Some lane is full |
| half_full | output | 1 | Lane 0 at least half occupied |
| empty | output | 1 | All lanes empty |
| word_avail | output | 1 | Every lane has an entry |
| byte_avail | output | 1 | Lane 0 has an entry |

## Verification
The bench targets these corner cases:
- A 17th word written into a full buffer. A design that let it through would overwrite the oldest bytes.
- A word read while one lane is empty. A design that accepted it would pop the other lanes and leave the lanes misaligned.
- The lane index after a refused shifter pop and after a clear arriving mid-word. A design that advanced the index there would scramble byte order for the rest of the transfer.
- Same-cycle push and pop on a lane, and host strobes colliding with shifter strobes. A design that handled these wrongly would drift in occupancy or lose bytes, and the flags would disagree with the queues of the behavioural model.

// File: rtl/lanefifo_pkg.sv
package lanefifo_pkg;
  typedef struct packed {
    logic full;
    logic half;
    logic empty;
    logic word_av;
    logic byte_av;
  } lf_flags_t;
endpackage

// File: rtl/lanefifo_lane.sv
// One byte lane: circular store, pointers and occupancy count.
// push/pop arrive already qualified by the top level.
module lanefifo_lane #(
  parameter int DEPTH = 16,
  parameter int W     = 8,
  localparam int AW   = $clog2(DEPTH),
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr,
  input  logic          push,
  input  logic          pop,
  input  logic [W-1:0]  din,
  output logic [W-1:0]  head,
  output logic [CW-1:0] cnt_q,
  output logic [CW-1:0] cnt_nxt
);
  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wptr, rptr;

  always_ff @(posedge clk) begin
    if (push) mem[wptr] <= din;
  end

  assign head    = mem[rptr];
  assign cnt_nxt = clr ? '0 : cnt_q + CW'(push) - CW'(pop);

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      wptr  <= '0;
      rptr  <= '0;
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_nxt;
      if (push) wptr <= (wptr == AW'(DEPTH - 1)) ? '0 : wptr + AW'(1);
      if (pop)  rptr <= (rptr == AW'(DEPTH - 1)) ? '0 : rptr + AW'(1);
    end
  end
endmodule

// File: rtl/lanefifo_seq.sv
// Rotating lane index for the shifter side (R4, R5, R6).
module lanefifo_seq #(
  parameter int LANES = 4,
  localparam int LW   = $clog2(LANES)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr,
  input  logic          word_mode,
  input  logic          step,
  output logic [LW-1:0] lane
);
  logic [LW-1:0] ptr;

  always_ff @(posedge clk) begin
    if (rst || clr) ptr <= '0;
    else if (step && word_mode)
      ptr <= (ptr == LW'(LANES - 1)) ? '0 : ptr + LW'(1);
  end

  assign lane = word_mode ? ptr : '0;
endmodule

// File: rtl/lanefifo_flags.sv
// Registered status flags computed from next-cycle occupancies (R7-R10, R13).
module lanefifo_flags
  import lanefifo_pkg::*;
#(
  parameter int LANES = 4,
  parameter int DEPTH = 16,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [LANES*CW-1:0] cnt_nxt,
  output lf_flags_t          flags_q
);
  localparam logic [CW-1:0] FULL_C = CW'(DEPTH);
  localparam logic [CW-1:0] HALF_C = CW'(DEPTH / 2);

  lf_flags_t f_d;

  always_comb begin
    f_d.full    = 1'b0;
    f_d.empty   = 1'b1;
    f_d.word_av = 1'b1;
    for (int l = 0; l < LANES; l++) begin
      if (cnt_nxt[l*CW +: CW] == FULL_C) f_d.full = 1'b1;
      if (cnt_nxt[l*CW +: CW] != '0)     f_d.empty = 1'b0;
      if (cnt_nxt[l*CW +: CW] == '0)     f_d.word_av = 1'b0;
    end
    f_d.half    = cnt_nxt[CW-1:0] >= HALF_C;
    f_d.byte_av = cnt_nxt[CW-1:0] != '0;
  end

  always_ff @(posedge clk) begin
    if (rst) flags_q <= '{full: 1'b0, half: 1'b0, empty: 1'b1, word_av: 1'b0, byte_av: 1'b0};
    else     flags_q <= f_d;
  end
endmodule

// File: rtl/lane_split_fifo.sv
// Four byte lanes addressed together as a word or singly as a byte.
module lane_split_fifo
  import lanefifo_pkg::*;
#(
  parameter int LANES  = 4,
  parameter int LANE_W = 8,
  parameter int DEPTH  = 16,
  localparam int WW    = LANES * LANE_W,
  localparam int CW    = $clog2(DEPTH + 1),
  localparam int LW    = $clog2(LANES)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clr,
  input  logic              word_mode,
  input  logic              host_wr_word,
  input  logic              host_wr_byte,
  input  logic [WW-1:0]     host_wdata,
  input  logic              host_rd_word,
  input  logic              host_rd_byte,
  output logic [WW-1:0]     host_rdata,
  input  logic              shf_push,
  input  logic [LANE_W-1:0] shf_wdata,
  input  logic              shf_pop,
  output logic [LANE_W-1:0] shf_rdata,
  output logic              full,
  output logic              half_full,
  output logic              empty,
  output logic              word_avail,
  output logic              byte_avail
);
  localparam logic [CW-1:0] FULL_C = CW'(DEPTH);

  logic [LANE_W-1:0]   heads   [LANES];
  logic [CW-1:0]       cnt_q   [LANES];
  logic [CW-1:0]       cnt_nx  [LANES];
  logic [LANES*CW-1:0] cnt_flat;
  logic [LANES-1:0]    room, have, lane_push, lane_pop;
  logic [LW-1:0]       push_lane, pop_lane;
  logic                wr_word_ok, wr_byte_ok, rd_word_ok, rd_byte_ok;
  logic                spush_ok, spop_ok, host_wr_ok;
  lf_flags_t           flags;

  always_comb begin
    for (int l = 0; l < LANES; l++) begin
      room[l] = cnt_q[l] != FULL_C;
      have[l] = cnt_q[l] != '0;
      cnt_flat[l*CW +: CW] = cnt_nx[l];
    end
  end

  // Acceptance, with clr over everything and host over shifter (R12)
  assign wr_word_ok = !clr && host_wr_word && (&room);
  assign wr_byte_ok = !clr && !host_wr_word && host_wr_byte && room[0];
  assign rd_word_ok = !clr && host_rd_word && (&have);
  assign rd_byte_ok = !clr && !host_rd_word && host_rd_byte && have[0];
  assign spush_ok   = !clr && shf_push && !(host_wr_word || host_wr_byte) && room[push_lane];
  assign spop_ok    = !clr && shf_pop && !(host_rd_word || host_rd_byte) && have[pop_lane];
  assign host_wr_ok = wr_word_ok || wr_byte_ok;

  lanefifo_seq #(.LANES(LANES)) u_push_seq (
    .clk(clk), .rst(rst), .clr(clr), .word_mode(word_mode),
    .step(spush_ok), .lane(push_lane)
  );

  lanefifo_seq #(.LANES(LANES)) u_pop_seq (
    .clk(clk), .rst(rst), .clr(clr), .word_mode(word_mode),
    .step(spop_ok), .lane(pop_lane)
  );

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [LANE_W-1:0] din;
    if (g == 0) begin : g_l0
      assign lane_push[g] = wr_word_ok || wr_byte_ok || (spush_ok && push_lane == LW'(g));
      assign lane_pop[g]  = rd_word_ok || rd_byte_ok || (spop_ok && pop_lane == LW'(g));
    end else begin : g_ln
      assign lane_push[g] = wr_word_ok || (spush_ok && push_lane == LW'(g));
      assign lane_pop[g]  = rd_word_ok || (spop_ok && pop_lane == LW'(g));
    end
    assign din = host_wr_ok ? host_wdata[g*LANE_W +: LANE_W] : shf_wdata;

    lanefifo_lane #(.DEPTH(DEPTH), .W(LANE_W)) u_lane (
      .clk(clk), .rst(rst), .clr(clr),
      .push(lane_push[g]), .pop(lane_pop[g]), .din(din),
      .head(heads[g]), .cnt_q(cnt_q[g]), .cnt_nxt(cnt_nx[g])
    );
  end

  lanefifo_flags #(.LANES(LANES), .DEPTH(DEPTH)) u_flags (
    .clk(clk), .rst(rst), .cnt_nxt(cnt_flat), .flags_q(flags)
  );

  // Registered data outputs (R2, R3, R4)
  always_ff @(posedge clk) begin
    if (rst) begin
      host_rdata <= '0;
      shf_rdata  <= '0;
    end else begin
      if (rd_word_ok) begin
        for (int l = 0; l < LANES; l++) host_rdata[l*LANE_W +: LANE_W] <= heads[l];
      end else if (rd_byte_ok) begin
        host_rdata <= {{(WW - LANE_W){1'b0}}, heads[0]};
      end
      if (spop_ok) shf_rdata <= heads[pop_lane];
    end
  end

  assign full       = flags.full;
  assign half_full  = flags.half;
  assign empty      = flags.empty;
  assign word_avail = flags.word_av;
  assign byte_avail = flags.byte_av;
endmodule

// File: rtl/lane_split_fifo_chk.sv
module lane_split_fifo_chk #(
  parameter int WW = 32,
  parameter int BW = 8
) (
  input logic          clk,
  input logic          rst,
  input logic          clr,
  input logic          host_rd_word,
  input logic          host_rd_byte,
  input logic          shf_pop,
  input logic [WW-1:0] host_rdata,
  input logic [BW-1:0] shf_rdata,
  input logic          full,
  input logic          half_full,
  input logic          empty,
  input logic          word_avail,
  input logic          byte_avail
);
  assert_clear_empties_R1: assert property (@(posedge clk) disable iff (rst)
    clr |=> (empty && !full && !half_full && !word_avail && !byte_avail));

  assert_full_not_empty_R7: assert property (@(posedge clk) disable iff (rst)
    !(full && empty));

  assert_full_persists_R7: assert property (@(posedge clk) disable iff (rst)
    (full && !clr && !shf_pop && !host_rd_word && !host_rd_byte) |=> full);

  assert_empty_no_avail_R8: assert property (@(posedge clk) disable iff (rst)
    empty |-> (!byte_avail && !word_avail));

  assert_pop_empty_shf_hold_R8: assert property (@(posedge clk) disable iff (rst)
    (empty && shf_pop && !clr) |=> $stable(shf_rdata));

  assert_pop_empty_host_hold_R8: assert property (@(posedge clk) disable iff (rst)
    (empty && (host_rd_word || host_rd_byte) && !clr) |=> $stable(host_rdata));

  assert_half_has_byte_R9: assert property (@(posedge clk) disable iff (rst)
    half_full |-> byte_avail);

  assert_word_implies_byte_R10: assert property (@(posedge clk) disable iff (rst)
    word_avail |-> byte_avail);
endmodule

bind lane_split_fifo lane_split_fifo_chk #(.WW(WW), .BW(LANE_W)) u_chk (
  .clk(clk), .rst(rst), .clr(clr),
  .host_rd_word(host_rd_word), .host_rd_byte(host_rd_byte), .shf_pop(shf_pop),
  .host_rdata(host_rdata), .shf_rdata(shf_rdata),
  .full(full), .half_full(half_full), .empty(empty),
  .word_avail(word_avail), .byte_avail(byte_avail)
);

// File: tb/tb_lane_split_fifo.sv
`timescale 1ns/1ps
module tb_lane_split_fifo;
  localparam int D = 16;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic clr = 1'b0, word_mode = 1'b1;
  logic host_wr_word = 1'b0, host_wr_byte = 1'b0, host_rd_word = 1'b0, host_rd_byte = 1'b0;
  logic shf_push = 1'b0, shf_pop = 1'b0;
  logic [31:0] host_wdata = '0;
  logic [7:0]  shf_wdata = '0;
  logic [31:0] host_rdata;
  logic [7:0]  shf_rdata;
  logic full, half_full, empty, word_avail, byte_avail;

  lane_split_fifo dut (
    .clk(clk), .rst(rst), .clr(clr), .word_mode(word_mode),
    .host_wr_word(host_wr_word), .host_wr_byte(host_wr_byte), .host_wdata(host_wdata),
    .host_rd_word(host_rd_word), .host_rd_byte(host_rd_byte), .host_rdata(host_rdata),
    .shf_push(shf_push), .shf_wdata(shf_wdata), .shf_pop(shf_pop), .shf_rdata(shf_rdata),
    .full(full), .half_full(half_full), .empty(empty),
    .word_avail(word_avail), .byte_avail(byte_avail)
  );

  always #4 clk = ~clk;

  int n_checks = 0, n_fail = 0;
  string phase = "R1 reset";

  // Behavioural reference model
  logic [7:0]  q [4][$];
  int          c [4];
  int          wp = 0, rp = 0, ln;
  logic        allc, allr;
  logic [31:0] m_hr = '0, tmp;
  logic [7:0]  m_sr = '0;

  always @(posedge clk) begin
    if (rst || clr) begin
      for (int l = 0; l < 4; l++) q[l].delete();
      wp = 0; rp = 0;
      if (rst) begin m_hr = '0; m_sr = '0; end
    end else begin
      allc = 1'b1; allr = 1'b1;
      for (int l = 0; l < 4; l++) begin
        c[l] = q[l].size();
        if (c[l] == 0) allc = 1'b0;
        if (c[l] == D) allr = 1'b0;
      end
      if (host_rd_word) begin
        if (allc) begin
          for (int l = 0; l < 4; l++) tmp[l*8 +: 8] = q[l].pop_front();
          m_hr = tmp;
        end
      end else if (host_rd_byte) begin
        if (c[0] > 0) m_hr = {24'h0, q[0].pop_front()};
      end else if (shf_pop) begin
        ln = word_mode ? rp : 0;
        if (c[ln] > 0) begin
          m_sr = q[ln].pop_front();
          if (word_mode) rp = (rp + 1) % 4;
        end
      end
      if (host_wr_word) begin
        if (allr) for (int l = 0; l < 4; l++) q[l].push_back(host_wdata[l*8 +: 8]);
      end else if (host_wr_byte) begin
        if (c[0] < D) q[0].push_back(host_wdata[7:0]);
      end else if (shf_push) begin
        ln = word_mode ? wp : 0;
        if (c[ln] < D) begin
          q[ln].push_back(shf_wdata);
          if (word_mode) wp = (wp + 1) % 4;
        end
      end
    end
  end

  function automatic logic m_full();
    for (int l = 0; l < 4; l++) if (q[l].size() == D) return 1'b1;
    return 1'b0;
  endfunction
  function automatic logic m_empty();
    for (int l = 0; l < 4; l++) if (q[l].size() != 0) return 1'b0;
    return 1'b1;
  endfunction
  function automatic logic m_wav();
    for (int l = 0; l < 4; l++) if (q[l].size() == 0) return 1'b0;
    return 1'b1;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s [%s] t=%0t actual=%h expected=%h", req, phase, $time, act, exp);
    end
  endtask

  // Compare every cycle, away from the active edge (R13: outputs move one cycle after access)
  always @(negedge clk) begin
    if (!rst) begin
      chk("R7 full",        {31'd0, full},       {31'd0, m_full()});
      chk("R8 empty",       {31'd0, empty},      {31'd0, m_empty()});
      chk("R9 half_full",   {31'd0, half_full},  {31'd0, (q[0].size() >= D/2)});
      chk("R10 word_avail", {31'd0, word_avail}, {31'd0, m_wav()});
      chk("R10 byte_avail", {31'd0, byte_avail}, {31'd0, (q[0].size() != 0)});
      chk("R2 R3 host_rdata", host_rdata, m_hr);
      chk("R4 shf_rdata",   {24'd0, shf_rdata},  {24'd0, m_sr});
    end
  end

  task automatic idle();
    host_wr_word = 0; host_wr_byte = 0; host_rd_word = 0; host_rd_byte = 0;
    shf_push = 0; shf_pop = 0; clr = 0;
  endtask
  task automatic tick(); @(negedge clk); endtask

  initial begin
    repeat (3) tick();
    rst = 1'b0;
    phase = "R1 reset state";
    n_checks++;
    if (!(empty && !full && !half_full && !word_avail && !byte_avail)) begin
      n_fail++;
      $display("FAIL R1 reset flags actual=%b expected=10000", {empty, full, half_full, word_avail, byte_avail});
    end
    repeat (2) tick();

    phase = "R2 R7 word fill past full";
    word_mode = 1;
    for (int i = 0; i < D + 1; i++) begin
      idle(); host_wr_word = 1; host_wdata = 32'hA0B0C0D0 + i * 32'h01010101; tick();
    end
    phase = "R2 R8 word drain past empty";
    for (int i = 0; i < D + 1; i++) begin idle(); host_rd_word = 1; tick(); end

    phase = "R4 R8 shifter pop lane order";
    for (int i = 0; i < 2; i++) begin
      idle(); host_wr_word = 1; host_wdata = 32'h44332211 + i * 32'h10101010; tick();
    end
    for (int i = 0; i < 9; i++) begin idle(); shf_pop = 1; tick(); end

    phase = "R5 shifter push lane order";
    for (int i = 0; i < 9; i++) begin idle(); shf_push = 1; shf_wdata = 8'h60 + 8'(i); tick(); end
    phase = "R2 read of pushed words, one lane short";
    for (int i = 0; i < 3; i++) begin idle(); host_rd_word = 1; tick(); end
    idle(); host_rd_byte = 1; tick();

    phase = "R3 R7 R9 byte fill and drain";
    word_mode = 0;
    for (int i = 0; i < D + 1; i++) begin
      idle(); host_wr_byte = 1; host_wdata = 32'hFFFFFF00 | i; tick();
    end
    for (int i = 0; i < D + 1; i++) begin idle(); host_rd_byte = 1; tick(); end

    phase = "R6 byte-mode shifter";
    for (int i = 0; i < 5; i++) begin idle(); shf_push = 1; shf_wdata = 8'h80 + 8'(i); tick(); end
    for (int i = 0; i < 6; i++) begin idle(); shf_pop = 1; tick(); end

    phase = "R11 push and pop together";
    for (int i = 0; i < 3; i++) begin idle(); host_wr_byte = 1; host_wdata = 32'h90 + i; tick(); end
    for (int i = 0; i < 4; i++) begin
      idle(); host_wr_byte = 1; host_wdata = 32'hC0 + i; shf_pop = 1; tick();
    end
    word_mode = 1;
    idle(); host_rd_byte = 1; tick(); tick(); tick(); tick(); tick(); tick(); tick(); tick();
    idle(); host_wr_word = 1; host_wdata = 32'h01020304; tick();
    for (int i = 0; i < 3; i++) begin
      idle(); host_wr_word = 1; host_wdata = 32'h11223344 * (i + 1); host_rd_word = 1; tick();
    end

    phase = "R12 strobe precedence";
    idle(); host_wr_word = 1; host_wr_byte = 1; host_wdata = 32'hDEADBEEF; shf_push = 1; shf_wdata = 8'h5A; tick();
    idle(); host_wr_byte = 1; host_wdata = 32'h77; shf_push = 1; shf_wdata = 8'hA5; tick();
    idle(); host_rd_byte = 1; shf_pop = 1; tick();
    idle(); host_rd_word = 1; host_rd_byte = 1; tick();
    idle(); shf_pop = 1; tick();

    phase = "R1 clear mid-word";
    idle(); host_wr_word = 1; host_wdata = 32'hCAFEF00D; tick();
    idle(); shf_pop = 1; tick();
    idle(); clr = 1; host_wr_word = 1; host_wdata = 32'h12345678; tick();
    idle(); host_wr_word = 1; host_wdata = 32'h0A0B0C0D; tick();
    for (int i = 0; i < 4; i++) begin idle(); shf_pop = 1; tick(); end

    phase = "R13 random mix";
    for (int i = 0; i < 3000; i++) begin
      idle();
      host_wr_word = ($urandom % 6) == 0;
      host_wr_byte = ($urandom % 8) == 0;
      host_rd_word = ($urandom % 7) == 0;
      host_rd_byte = ($urandom % 9) == 0;
      shf_push = ($urandom % 3) == 0;
      shf_pop = ($urandom % 3) == 0;
      clr = ($urandom % 150) == 0;
      host_wdata = $urandom;
      shf_wdata = 8'($urandom);
      if (($urandom % 200) == 0) word_mode = ~word_mode;
      tick();
    end
    idle(); tick(); tick();

    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_checks++; n_fail++;
    $display("FAIL watchdog expired in phase [%s]", phase);
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end
endmodule